// File: doc/BRIEF.md
# PWM Generator with AXI4-Lite Register Port

The block produces one pulse-width-modulated output. Its frequency and high time come from two configuration words that a processor writes over a 32-bit AXI4-Lite slave port. A period counter steps once per clock from 0 up to the programmed period and then starts over at 0, so one PWM cycle lasts period+1 clocks. The output is high while the compare word is above the current count.

The register space holds four 32-bit words at byte addresses that step by 4:

| Offset | Word | Access |
|--------|------|--------|
| 0x0 | period | read/write, byte strobes apply |
| 0x4 | compare | read/write, byte strobes apply |
| 0x8 | live count | read-only, writes are ignored |
| 0xC | reserved | reads zero, writes are ignored |

Software sets the frequency with the period word. It sets the duty either as a fraction of the period or as an absolute number of clocks. It can read the count to follow the running waveform. Only single-beat, full-width accesses are handled, and every response is OKAY.

Top module: `axil_pwm`

## Requirements
- R1: While rst_ni is low at a rising clock edge, the period word, the compare word and the count all clear to 0. After reset, reads of offsets 0x0, 0x4 and 0x8 return 0, pwm_o is low, and the count stays at 0 until a period is written.
- R2: A write to offset 0x0 updates the period word and a write to offset 0x4 updates the compare word. Only the bytes whose s_wstrb_i bit is set change: bit n covers data bits 8n+7..8n. A read of the same offset returns the stored word.
- R3: At each clock edge the count increments when it is below the period word, and otherwise becomes 0. With period P held steady, pwm_o therefore repeats every P+1 clocks. Lowering the period below the current count sends the count to 0 at the next edge.
- R4: pwm_o is high exactly when the compare word is greater than the count, treating both as unsigned. A compare of 0 keeps the output low, and a compare above the period keeps it high.
- R5: A read of offset 0x8 returns the count as it stood in the cycle in which the read address was accepted.
- R6: A write to offset 0x8 leaves the count unchanged. A write to offset 0xC changes nothing, and a read of 0xC returns 0.
- R7: The write address and the write data are accepted in either order or in the same cycle. s_bvalid_o rises no earlier than the cycle after the later of the two handshakes. It then stays high, with s_bresp_o = 2'b00 (OKAY), until s_bready_i is seen high.
- R8: After a read address handshake, s_rvalid_o rises in the next cycle. It stays high with s_rdata_o stable and s_rresp_o = 2'b00 (OKAY) until s_rready_i is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, sampled on the clock |
| s_awaddr_i | input | ADDR_W | Write byte address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response, always OKAY |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read byte address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response, always OKAY |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| pwm_o | output | 1 | PWM output |

## Verification
The bench aims at the following corner cases:

- **Split writes.** Address and data arrive with long gaps between them in both orders. A design that commits on the first handshake would write with stale data or a stale address, or raise the response too early.
- **Partial byte strobes.** A design that ignores s_wstrb_i would overwrite bytes that should have been kept.
- **Writes to the read-only word.** A write to the count must not move it. A design that decodes the count as writable would fold the written value into the count or into the waveform.
- **Shrinking the period.** The period is lowered below the current count, and two compare extremes are tried: compare = 0 and compare above the period. A counter that waits for equality before wrapping would run on for about 2^32 clocks. An off-by-one comparison would show up as a mismatch of pwm_o in the cycle-by-cycle comparison against the model.

// File: rtl/axil_pwm_pkg.sv
package axil_pwm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned SEL_LSB = 2;  // byte addressing, word stride 4

  typedef enum logic [SEL_W-1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CMP    = 2'd1,
    SEL_CNT    = 2'd2,
    SEL_RSV    = 2'd3
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/axil_pwm_wr.sv
module axil_pwm_wr
  import axil_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  word_t             wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              wr_en_o,
  output reg_sel_e          wr_sel_o,
  output word_t             wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o
);
  logic              aw_got_q;
  logic              w_got_q;
  logic              bvalid_q;
  reg_sel_e          sel_q;
  word_t             data_q;
  logic [STRB_W-1:0] strb_q;
  logic              aw_hs;
  logic              w_hs;

  // no new beat is taken while a response is pending
  assign awready_o = !aw_got_q && !bvalid_q;
  assign wready_o  = !w_got_q && !bvalid_q;
  assign aw_hs     = awvalid_i && awready_o;
  assign w_hs      = wvalid_i && wready_o;

  // commit one cycle after both halves are held
  assign wr_en_o   = aw_got_q && w_got_q;
  assign wr_sel_o  = sel_q;
  assign wr_data_o = data_q;
  assign wr_strb_o = strb_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      bvalid_q <= 1'b0;
      sel_q    <= SEL_PERIOD;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      if (aw_hs) begin
        aw_got_q <= 1'b1;
        sel_q    <= reg_sel_e'(awaddr_i[SEL_LSB +: SEL_W]);
      end
      if (w_hs) begin
        w_got_q <= 1'b1;
        data_q  <= wdata_i;
        strb_q  <= wstrb_i;
      end
      if (wr_en_o) begin
        aw_got_q <= 1'b0;
        w_got_q  <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_pwm_rd.sv
module axil_pwm_rd
  import axil_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output word_t             rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  word_t             period_i,
  input  word_t             cmp_i,
  input  word_t             cnt_i
);
  logic     rvalid_q;
  word_t    rdata_q;
  word_t    rd_mux;
  reg_sel_e rd_sel;

  assign rd_sel    = reg_sel_e'(araddr_i[SEL_LSB +: SEL_W]);
  assign arready_o = !rvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = RESP_OKAY;

  always_comb begin
    unique case (rd_sel)
      SEL_PERIOD: rd_mux = period_i;
      SEL_CMP:    rd_mux = cmp_i;
      SEL_CNT:    rd_mux = cnt_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;  // count sampled at address acceptance
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/axil_pwm_regs.sv
module axil_pwm_regs
  import axil_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  word_t             wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  output word_t             period_o,
  output word_t             cmp_o
);
  logic per_hit;
  logic cmp_hit;

  assign per_hit = wr_en_i && (wr_sel_i == SEL_PERIOD);
  assign cmp_hit = wr_en_i && (wr_sel_i == SEL_CMP);

  for (genvar b = 0; b < STRB_W; b++) begin : g_byte
    logic [7:0] per_b_q;
    logic [7:0] cmp_b_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        per_b_q <= '0;
        cmp_b_q <= '0;
      end else begin
        if (per_hit && wr_strb_i[b]) per_b_q <= wr_data_i[b*8 +: 8];
        if (cmp_hit && wr_strb_i[b]) cmp_b_q <= wr_data_i[b*8 +: 8];
      end
    end

    assign period_o[b*8 +: 8] = per_b_q;
    assign cmp_o[b*8 +: 8]    = cmp_b_q;
  end
endmodule

// File: rtl/axil_pwm_core.sv
module axil_pwm_core
  import axil_pwm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t period_i,
  input  word_t cmp_i,
  output word_t cnt_o,
  output logic  pwm_o
);
  word_t cnt_q;

  // less-than wrap also recovers when the period drops below the count
  always_ff @(posedge clk_i) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q < period_i) cnt_q <= cnt_q + word_t'(1);
    else                       cnt_q <= '0;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = cmp_i > cnt_q;
endmodule

// File: rtl/axil_pwm.sv
module axil_pwm
  import axil_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [31:0]       s_wdata_i,
  input  logic [3:0]        s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [31:0]       s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic              pwm_o
);
  logic              wr_en;
  reg_sel_e          wr_sel;
  word_t             wr_data;
  logic [STRB_W-1:0] wr_strb;
  word_t             per_q;
  word_t             cmp_q;
  word_t             cnt_q;

  axil_pwm_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awaddr_i  (s_awaddr_i),
    .awvalid_i (s_awvalid_i),
    .awready_o (s_awready_o),
    .wdata_i   (s_wdata_i),
    .wstrb_i   (s_wstrb_i),
    .wvalid_i  (s_wvalid_i),
    .wready_o  (s_wready_o),
    .bresp_o   (s_bresp_o),
    .bvalid_o  (s_bvalid_o),
    .bready_i  (s_bready_i),
    .wr_en_o   (wr_en),
    .wr_sel_o  (wr_sel),
    .wr_data_o (wr_data),
    .wr_strb_o (wr_strb)
  );

  axil_pwm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .wr_strb_i (wr_strb),
    .period_o  (per_q),
    .cmp_o     (cmp_q)
  );

  axil_pwm_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (per_q),
    .cmp_i    (cmp_q),
    .cnt_o    (cnt_q),
    .pwm_o    (pwm_o)
  );

  axil_pwm_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .araddr_i  (s_araddr_i),
    .arvalid_i (s_arvalid_i),
    .arready_o (s_arready_o),
    .rdata_o   (s_rdata_o),
    .rresp_o   (s_rresp_o),
    .rvalid_o  (s_rvalid_o),
    .rready_i  (s_rready_i),
    .period_i  (per_q),
    .cmp_i     (cmp_q),
    .cnt_i     (cnt_q)
  );
endmodule

// File: rtl/axil_pwm_chk.sv
module axil_pwm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] per_i,
  input logic [31:0] cmp_i,
  input logic [31:0] cnt_i,
  input logic        pwm_i,
  input logic        awready_i,
  input logic        wready_i,
  input logic        bvalid_i,
  input logic        bready_i,
  input logic [1:0]  bresp_i,
  input logic        rvalid_i,
  input logic        rready_i,
  input logic [31:0] rdata_i,
  input logic [1:0]  rresp_i
);
  // R3: count either steps by one or returns to zero
  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cnt_i == 32'd0) || (cnt_i == $past(cnt_i) + 32'd1));

  // R3: a count at or above the period goes to zero next
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >= per_i) |=> (cnt_i == 32'd0));

  // R4: compare of zero holds output low
  a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == 32'd0) |-> !pwm_i);

  // R4: compare above period holds output high
  a_r4_over_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_i > per_i) && (cnt_i <= per_i)) |-> pwm_i);

  // R7: response held until taken, OKAY, and no new beat meanwhile
  a_r7_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_i && !bready_i) |=> bvalid_i);

  a_r7_b_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_i |-> (bresp_i == 2'b00) && !awready_i && !wready_i);

  // R8: read data held stable until taken, OKAY
  a_r8_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && !rready_i) |=> rvalid_i && $stable(rdata_i));

  a_r8_r_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> (rresp_i == 2'b00));
endmodule

bind axil_pwm axil_pwm_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .per_i     (per_q),
  .cmp_i     (cmp_q),
  .cnt_i     (cnt_q),
  .pwm_i     (pwm_o),
  .awready_i (s_awready_o),
  .wready_i  (s_wready_o),
  .bvalid_i  (s_bvalid_o),
  .bready_i  (s_bready_i),
  .bresp_i   (s_bresp_o),
  .rvalid_i  (s_rvalid_o),
  .rready_i  (s_rready_i),
  .rdata_i   (s_rdata_o),
  .rresp_i   (s_rresp_o)
);

// File: tb/tb_axil_pwm.sv
`timescale 1ns/1ps
module tb_axil_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [3:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic        pwm;

  axil_pwm #(.ADDR_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(s_awaddr), .s_awvalid_i(s_awvalid), .s_awready_o(s_awready),
    .s_wdata_i(s_wdata), .s_wstrb_i(s_wstrb), .s_wvalid_i(s_wvalid), .s_wready_o(s_wready),
    .s_bresp_o(s_bresp), .s_bvalid_o(s_bvalid), .s_bready_i(s_bready),
    .s_araddr_i(s_araddr), .s_arvalid_i(s_arvalid), .s_arready_o(s_arready),
    .s_rdata_o(s_rdata), .s_rresp_o(s_rresp), .s_rvalid_o(s_rvalid), .s_rready_i(s_rready),
    .pwm_o(pwm)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit pwm_chk = 1'b0;
  logic [31:0] m_per = '0;
  logic [31:0] m_cmp = '0;
  logic [31:0] m_cnt = '0;

  // reference count from R3
  always @(posedge clk) begin
    if (!rst_n) m_cnt <= '0;
    else        m_cnt <= (m_cnt < m_per) ? m_cnt + 32'd1 : 32'd0;
  end

  // R4: output compared every cycle
  always @(negedge clk) begin
    #1;
    if (pwm_chk && rst_n && !done) begin
      checks++;
      if (pwm !== (m_cmp > m_cnt)) begin
        fails++;
        $display("FAIL R4 pwm_o got %0b exp %0b (cnt=%0d cmp=%0d per=%0d)",
                 pwm, (m_cmp > m_cnt), m_cnt, m_cmp, m_per);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got 0x%08h exp 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                        input logic [3:0] strb);
    logic [31:0] r = old_v;
    for (int b = 0; b < 4; b++) if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sel, input logic [31:0] cnt);
    case (sel)
      2'd0:    return m_per;
      2'd1:    return m_cmp;
      2'd2:    return cnt;
      default: return 32'd0;
    endcase
  endfunction

  // entered and left at a negedge
  task automatic axi_wr(input logic [3:0] addr, input logic [31:0] data, input logic [3:0] strb,
                        input int da, input int dw, input int db);
    int n;
    fork
      begin
        bit ok;
        repeat (da) @(negedge clk);
        s_awaddr = addr; s_awvalid = 1'b1;
        forever begin ok = s_awready; @(posedge clk); if (ok) break; @(negedge clk); end
        @(negedge clk); s_awvalid = 1'b0;
      end
      begin
        bit ok;
        for (int i = 0; i < dw; i++) begin
          @(negedge clk);
          chk("R7 no response before data", {31'd0, s_bvalid}, 32'd0);
        end
        s_wdata = data; s_wstrb = strb; s_wvalid = 1'b1;
        forever begin ok = s_wready; @(posedge clk); if (ok) break; @(negedge clk); end
        @(negedge clk); s_wvalid = 1'b0;
      end
    join
    chk("R7 response not in handshake cycle", {31'd0, s_bvalid}, 32'd0);
    n = 0;
    while (!s_bvalid && n < 8) begin @(negedge clk); n++; end
    if (addr[3:2] == 2'd0) m_per = merge(m_per, data, strb);
    if (addr[3:2] == 2'd1) m_cmp = merge(m_cmp, data, strb);
    chk("R7 bvalid raised", {31'd0, s_bvalid}, 32'd1);
    chk("R7 bresp okay", {30'd0, s_bresp}, 32'd0);
    for (int i = 0; i < db; i++) begin
      @(negedge clk);
      chk("R7 bvalid held", {31'd0, s_bvalid}, 32'd1);
    end
    s_bready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_bready = 1'b0;
    chk("R7 bvalid dropped", {31'd0, s_bvalid}, 32'd0);
  endtask

  task automatic axi_rd(input string tag, input logic [3:0] addr, input int dr,
                        output logic [31:0] got);
    bit ok;
    int n;
    logic [31:0] exp;
    exp = '0;
    s_araddr = addr; s_arvalid = 1'b1;
    forever begin
      ok = s_arready;
      exp = exp_rd(addr[3:2], m_cnt);
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk); s_arvalid = 1'b0;
    chk("R8 rvalid next cycle", {31'd0, s_rvalid}, 32'd1);
    n = 0;
    while (!s_rvalid && n < 8) begin @(negedge clk); n++; end
    got = s_rdata;
    chk(tag, got, exp);
    chk("R8 rresp okay", {30'd0, s_rresp}, 32'd0);
    for (int i = 0; i < dr; i++) begin
      @(negedge clk);
      chk("R8 rvalid held", {31'd0, s_rvalid}, 32'd1);
      chk("R8 rdata stable", s_rdata, got);
    end
    s_rready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_rready = 1'b0;
    chk("R8 rvalid dropped", {31'd0, s_rvalid}, 32'd0);
  endtask

  task automatic measure(input int exp);
    int t = 0;
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    while (pwm) begin @(negedge clk); t++; end
    while (!pwm) begin @(negedge clk); t++; end
    chk("R3 pwm repeat length", t, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pwm_chk = 1'b1;

    // R1: reset state
    chk("R1 pwm low after reset", {31'd0, pwm}, 32'd0);
    axi_rd("R1 period reset", 4'h0, 0, v);
    axi_rd("R1 compare reset", 4'h4, 1, v);
    axi_rd("R1 count reset", 4'h8, 0, v);
    repeat (5) @(negedge clk);
    axi_rd("R1 count held at zero", 4'h8, 0, v);
    chk("R1 count still zero", v, 32'd0);

    // R2/R3/R7: split writes in both orders, then cycle length
    axi_wr(4'h0, 32'd4, 4'hF, 0, 3, 2);
    axi_wr(4'h4, 32'd2, 4'hF, 3, 0, 0);
    axi_rd("R2 period readback", 4'h0, 0, v);
    chk("R2 period value", v, 32'd4);
    axi_rd("R2 compare readback", 4'h4, 2, v);
    chk("R2 compare value", v, 32'd2);
    measure(5);
    axi_wr(4'h0, 32'd9, 4'hF, 1, 1, 1);
    measure(10);

    // R5: live count reads
    for (int i = 0; i < 4; i++) axi_rd("R5 count sample", 4'h8, i, v);

    // R2: byte strobes
    axi_wr(4'h0, 32'h1122_3344, 4'hF, 0, 0, 0);
    axi_wr(4'h0, 32'hAABB_CCDD, 4'b0101, 2, 0, 0);
    axi_rd("R2 strobe merge", 4'h0, 0, v);
    chk("R2 strobe value", v, 32'h11BB_33DD);
    // R3: period dropped below a large count
    axi_wr(4'h0, 32'h0000_0006, 4'hF, 0, 0, 0);
    axi_rd("R3 count after shrink", 4'h8, 0, v);
    chk("R3 count within period", {31'd0, (v <= 32'd6)}, 32'd1);
    axi_wr(4'h4, 32'hFF00_0003, 4'b0001, 0, 0, 0);
    axi_rd("R2 compare low byte", 4'h4, 0, v);
    chk("R2 compare value", v, 32'd3);

    // R6: read-only count and reserved word
    axi_wr(4'h8, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    axi_rd("R6 count unaffected", 4'h8, 0, v);
    axi_wr(4'hC, 32'h1234_5678, 4'hF, 1, 0, 0);
    axi_rd("R6 reserved reads zero", 4'hC, 0, v);
    chk("R6 reserved value", v, 32'd0);
    axi_rd("R6 period unchanged", 4'h0, 0, v);
    chk("R6 period value", v, 32'd6);
    axi_rd("R6 compare unchanged", 4'h4, 0, v);
    chk("R6 compare value", v, 32'd3);

    // R4: compare extremes
    axi_wr(4'h4, 32'd0, 4'hF, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); chk("R4 zero compare low", {31'd0, pwm}, 32'd0);
    end
    axi_wr(4'h4, 32'd7, 4'hF, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); chk("R4 compare above period high", {31'd0, pwm}, 32'd1);
    end

    // random mix
    for (int i = 0; i < 80; i++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0)
        axi_wr(4'h0, $urandom_range(0, 15), 4'hF, $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, 2));
      else if (op == 1)
        axi_wr(4'h4, $urandom_range(0, 18), 4'hF, $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, 2));
      else
        axi_rd("R5 random read", {$urandom_range(0, 3), 2'b00}, $urandom_range(0, 2), v);
      repeat ($urandom_range(0, 6)) @(negedge clk);
    end

    // R1: reset mid-run
    axi_wr(4'h0, 32'd12, 4'hF, 0, 0, 0);
    axi_wr(4'h4, 32'd5, 4'hF, 0, 0, 0);
    pwm_chk = 1'b0;
    rst_n = 1'b0;
    m_per = '0; m_cmp = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pwm_chk = 1'b1;
    @(negedge clk);
    chk("R1 pwm low after second reset", {31'd0, pwm}, 32'd0);
    axi_rd("R1 period cleared", 4'h0, 0, v);
    chk("R1 period value", v, 32'd0);
    axi_rd("R1 count cleared", 4'h8, 0, v);
    chk("R1 count value", v, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule